// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This block chooses the power mode a small microcontroller takes up when its core reports that a STOP instruction has run, and it also handles a direct request for standby that does not go through STOP. It reads the core's configuration bits each clock. The bits that matter are wait-enable, stop-enable, instruction-reset-disable, low-power request, partial-power-down control, debug-in-stop enable and a bus-slow flag.

From these bits it resolves STOP into wait, plain stop, standby (loose regulation) or partial power-down. A STOP that is not permitted becomes either a reset request or an illegal-instruction exception pulse.

The chosen mode is held in a register and shown on a 3-bit code. It stays there until a wake event brings the block back to run. Two outputs are decoded from the mode: a request to put the regulator in standby and a request to gate off most of the digital logic. Setting both low-power configuration bits at once is a configuration fault. It is recorded in a sticky flag.

Top module: `lpm_entry_ctrl`

## Requirements
- R1: After a synchronous reset the mode code is RUN (0), and the regulator-standby, logic-gate, reset-request, exception and configuration-error outputs are all 0.
- R2: A STOP strobe in RUN with wait-enable set moves the mode to WAIT (code 1), whatever stop-enable and the low-power bits hold.
- R3: A STOP strobe in RUN with wait-enable clear and stop-enable set moves the mode to STOP (code 2) when neither standby nor partial power-down is selected.
- R4: A STOP strobe with wait-enable clear and stop-enable set moves the mode to STANDBY (code 3) when all of the following hold: low-power request set, partial-power-down control clear, debug-in-stop clear, bus-slow set.
- R5: A STOP strobe with wait-enable clear and stop-enable set moves the mode to PPD (code 4) when partial-power-down control is set and both low-power request and debug-in-stop are clear.
- R6: When standby or partial power-down is selected but debug-in-stop is set, or when standby is selected while bus-slow is clear, a STOP strobe with stop-enable set gives plain STOP (code 2).
- R7: A STOP strobe in RUN with both enables clear leaves the mode at RUN. It raises the reset request for exactly one cycle if instruction-reset-disable is clear, and the exception output for exactly one cycle if it is set. The two outputs are never high together.
- R8: In RUN with no STOP strobe, a rising edge of the low-power request enters STANDBY (code 3) when partial-power-down control is clear, debug-in-stop is clear and bus-slow is set. Under any other condition the rising edge leaves the mode at RUN.
- R9: While the low-power request and partial-power-down control are both set, the configuration-error output is set and stays set until reset. A STOP strobe with stop-enable set then gives plain STOP (code 2).
- R10: The regulator-standby output is 1 exactly when the mode is STANDBY or PPD. The logic-gate output is 1 exactly when the mode is PPD.
- R11: In any mode other than RUN, STOP strobes and low-power request edges are ignored. A wake event returns the mode to RUN at the next edge, and a wake event in RUN has no effect.
- R12: The mode code and the pulse outputs change at the first clock edge that samples the triggering inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_exec | input | 1 | One-cycle strobe: core executed STOP |
| cfg_wait_en | input | 1 | STOP enters wait mode |
| cfg_stop_en | input | 1 | STOP enters a stop mode |
| cfg_irst_dis | input | 1 | Illegal STOP gives exception instead of reset |
| cfg_lp_req | input | 1 | Low-power (standby) request |
| cfg_ppd_ctl | input | 1 | Partial power-down selected for stop |
| cfg_dbg_stop | input | 1 | Debug kept alive in stop/wait |
| bus_slow | input | 1 | Bus clock is below the standby limit |
| wake | input | 1 | Wake event, returns to RUN |
| mode_o | output | 3 | Current mode code (RUN 0, WAIT 1, STOP 2, STANDBY 3, PPD 4) |
| reg_stby_o | output | 1 | Regulator standby request |
| logic_gate_o | output | 1 | Logic power-gate request |
| rst_req_o | output | 1 | One-cycle reset request |
| ill_exc_o | output | 1 | One-cycle illegal-instruction exception |
| cfg_err_o | output | 1 | Sticky low-power configuration error |

## Verification
The mode register is the only lasting state apart from the error flag and the low-power edge detector, so a wrong state shows on the mode code one cycle after the strobe that caused it. The regulator and gate outputs follow that code in the same cycle. A bad priority decision, such as standby granted under debug or partial power-down taken during a conflict, therefore appears at the first sample after the STOP strobe. Pulse-width and stickiness faults show at the sample one cycle later.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        M_RUN   = 3'd0,
        M_WAIT  = 3'd1,
        M_STOP  = 3'd2,
        M_STBY  = 3'd3,
        M_PPD   = 3'd4
    } lpm_mode_t;

    typedef struct packed {
        logic wait_en;
        logic stop_en;
        logic irst_dis;
        logic lp_req;
        logic ppd_ctl;
        logic dbg_stop;
        logic bus_slow;
    } lpm_cfg_t;

    typedef struct packed {
        lpm_mode_t target;
        logic      illegal;
        logic      conflict;
        logic      stby_ok;
    } lpm_decision_t;

    typedef struct packed {
        logic reg_stby;
        logic logic_gate;
    } lpm_power_t;

    function automatic lpm_power_t power_of(lpm_mode_t m);
        lpm_power_t p;
        p.reg_stby   = (m == M_STBY) || (m == M_PPD);
        p.logic_gate = (m == M_PPD);
        return p;
    endfunction

endpackage

// File: rtl/lpm_resolver.sv
module lpm_resolver
    import lpm_pkg::*;
(
    input  lpm_cfg_t      cfg,
    output lpm_decision_t dec
);

    logic conflict;
    logic stby_allowed;
    logic ppd_allowed;

    always_comb begin
        conflict     = cfg.lp_req && cfg.ppd_ctl;
        stby_allowed = cfg.lp_req && !cfg.ppd_ctl && !cfg.dbg_stop && cfg.bus_slow;
        ppd_allowed  = cfg.ppd_ctl && !cfg.lp_req && !cfg.dbg_stop;

        dec.conflict = conflict;
        dec.stby_ok  = stby_allowed;
        dec.illegal  = !cfg.wait_en && !cfg.stop_en;

        if (cfg.wait_en) begin
            dec.target = M_WAIT;
        end else if (cfg.stop_en) begin
            if (ppd_allowed) begin
                dec.target = M_PPD;
            end else if (stby_allowed) begin
                dec.target = M_STBY;
            end else begin
                dec.target = M_STOP;
            end
        end else begin
            dec.target = M_RUN;
        end
    end

endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
    import lpm_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          stop_exec,
    input  logic          wake,
    input  lpm_cfg_t      cfg,
    input  lpm_decision_t dec,
    output lpm_mode_t     mode,
    output logic          rst_req,
    output logic          ill_exc,
    output logic          cfg_err
);

    lpm_mode_t mode_q, mode_d;
    logic      lp_q;
    logic      lp_rise;
    logic      rst_d, exc_d;

    always_comb begin
        lp_rise = cfg.lp_req && !lp_q;
        mode_d  = mode_q;
        rst_d   = 1'b0;
        exc_d   = 1'b0;
        if (mode_q == M_RUN) begin
            if (stop_exec) begin
                if (dec.illegal) begin
                    rst_d = !cfg.irst_dis;
                    exc_d = cfg.irst_dis;
                end else begin
                    mode_d = dec.target;
                end
            end else if (lp_rise && dec.stby_ok) begin
                mode_d = M_STBY;
            end
        end else if (wake) begin
            mode_d = M_RUN;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= M_RUN;
            lp_q    <= 1'b0;
            rst_req <= 1'b0;
            ill_exc <= 1'b0;
            cfg_err <= 1'b0;
        end else begin
            mode_q  <= mode_d;
            lp_q    <= cfg.lp_req;
            rst_req <= rst_d;
            ill_exc <= exc_d;
            cfg_err <= cfg_err || dec.conflict;
        end
    end

    assign mode = mode_q;

    p_wait_first_r2: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_RUN && stop_exec && cfg.wait_en) |=> (mode_q == M_WAIT));

    p_conflict_plain_r9: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_RUN && stop_exec && !cfg.wait_en && cfg.stop_en
         && cfg.lp_req && cfg.ppd_ctl) |=> (mode_q == M_STOP));

    p_no_lowpower_in_debug_r6: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_RUN && stop_exec && cfg.dbg_stop)
        |=> (mode_q != M_STBY && mode_q != M_PPD));

    p_pulse_single_r7: assert property (@(posedge clk) disable iff (rst)
        (rst_req || ill_exc) |=> (!rst_req && !ill_exc));

    p_pulse_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rst_req, ill_exc}));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> cfg_err);

    p_hold_lowpower_r11: assert property (@(posedge clk) disable iff (rst)
        (mode_q != M_RUN && !wake) |=> $stable(mode_q));

    p_wake_returns_r11: assert property (@(posedge clk) disable iff (rst)
        (mode_q != M_RUN && wake) |=> (mode_q == M_RUN));

endmodule

// File: rtl/lpm_entry_ctrl.sv
module lpm_entry_ctrl
    import lpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stop_exec,
    input  logic              cfg_wait_en,
    input  logic              cfg_stop_en,
    input  logic              cfg_irst_dis,
    input  logic              cfg_lp_req,
    input  logic              cfg_ppd_ctl,
    input  logic              cfg_dbg_stop,
    input  logic              bus_slow,
    input  logic              wake,
    output logic [MODE_W-1:0] mode_o,
    output logic              reg_stby_o,
    output logic              logic_gate_o,
    output logic              rst_req_o,
    output logic              ill_exc_o,
    output logic              cfg_err_o
);

    lpm_cfg_t      cfg;
    lpm_decision_t dec;
    lpm_mode_t     mode;
    lpm_power_t    pwr;

    assign cfg = '{wait_en:  cfg_wait_en,
                   stop_en:  cfg_stop_en,
                   irst_dis: cfg_irst_dis,
                   lp_req:   cfg_lp_req,
                   ppd_ctl:  cfg_ppd_ctl,
                   dbg_stop: cfg_dbg_stop,
                   bus_slow: bus_slow};

    lpm_resolver u_resolver (
        .cfg (cfg),
        .dec (dec)
    );

    lpm_mode_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .stop_exec (stop_exec),
        .wake      (wake),
        .cfg       (cfg),
        .dec       (dec),
        .mode      (mode),
        .rst_req   (rst_req_o),
        .ill_exc   (ill_exc_o),
        .cfg_err   (cfg_err_o)
    );

    assign pwr          = power_of(mode);
    assign mode_o       = mode;
    assign reg_stby_o   = pwr.reg_stby;
    assign logic_gate_o = pwr.logic_gate;

    p_gate_implies_stby_r10: assert property (@(posedge clk) disable iff (rst)
        logic_gate_o |-> reg_stby_o);

    p_stby_needs_slow_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_o) == 3'd0 && mode_o == 3'd3) |-> $past(bus_slow && !cfg_dbg_stop));

endmodule

// File: tb/lpm_entry_ctrl_test.sv
`timescale 1ns/1ps
module lpm_entry_ctrl_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       stop_exec, cfg_wait_en, cfg_stop_en, cfg_irst_dis;
    logic       cfg_lp_req, cfg_ppd_ctl, cfg_dbg_stop, bus_slow, wake;
    logic [2:0] mode_o;
    logic       reg_stby_o, logic_gate_o, rst_req_o, ill_exc_o, cfg_err_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    lpm_entry_ctrl uut (
        .clk(clk), .rst(rst), .stop_exec(stop_exec),
        .cfg_wait_en(cfg_wait_en), .cfg_stop_en(cfg_stop_en),
        .cfg_irst_dis(cfg_irst_dis), .cfg_lp_req(cfg_lp_req),
        .cfg_ppd_ctl(cfg_ppd_ctl), .cfg_dbg_stop(cfg_dbg_stop),
        .bus_slow(bus_slow), .wake(wake), .mode_o(mode_o),
        .reg_stby_o(reg_stby_o), .logic_gate_o(logic_gate_o),
        .rst_req_o(rst_req_o), .ill_exc_o(ill_exc_o), .cfg_err_o(cfg_err_o)
    );

    // vector: [11]wait [10]stop [9]irst_dis [8]lp [7]ppd [6]dbg [5]slow
    //         [4:2]expected mode [1]expected rst_req [0]expected exception
    localparam int NV = 11;
    localparam logic [11:0] VEC [NV] = '{
        12'b1100000_001_00,   // R2 wait over stop
        12'b1001001_001_00,   // R2 wait over standby selection
        12'b0100000_010_00,   // R3 plain stop
        12'b0101001_011_00,   // R4 standby
        12'b0101000_010_00,   // R6 fast clock blocks standby
        12'b0101011_010_00,   // R6 debug blocks standby
        12'b0100100_100_00,   // R5 partial power-down
        12'b0100110_010_00,   // R6 debug blocks ppd
        12'b0000000_000_10,   // R7 reset request
        12'b0010000_000_01,   // R7 exception
        12'b1010000_001_00    // R2 wait with irst_dis set
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_inputs();
        stop_exec = 0; cfg_wait_en = 0; cfg_stop_en = 0; cfg_irst_dis = 0;
        cfg_lp_req = 0; cfg_ppd_ctl = 0; cfg_dbg_stop = 0; bus_slow = 0; wake = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_wake();
        wake = 1; step(); wake = 0;
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clear_inputs();
        rst = 1;
        step(); step();
        rst = 0;
        // R1 reset state
        chk("R1 mode", mode_o, 0);
        chk("R1 outs", {reg_stby_o, logic_gate_o, rst_req_o, ill_exc_o, cfg_err_o}, 0);

        for (int i = 0; i < NV; i++) begin
            logic [11:0] v;
            v = VEC[i];
            {cfg_wait_en, cfg_stop_en, cfg_irst_dis, cfg_lp_req,
             cfg_ppd_ctl, cfg_dbg_stop, bus_slow} = v[11:5];
            stop_exec = 1;
            step();
            stop_exec = 0;
            // R12 mode changes at the first edge
            chk($sformatf("R2-6 vec%0d mode", i), mode_o, v[4:2]);
            chk($sformatf("R7 vec%0d rst_req", i), rst_req_o, v[1]);
            chk($sformatf("R7 vec%0d ill_exc", i), ill_exc_o, v[0]);
            chk($sformatf("R10 vec%0d reg_stby", i), reg_stby_o, (v[4:2] == 3 || v[4:2] == 4));
            chk($sformatf("R10 vec%0d gate", i), logic_gate_o, (v[4:2] == 4));
            step();
            chk($sformatf("R7 vec%0d pulse end", i), rst_req_o | ill_exc_o, 0);
            do_wake();
            chk($sformatf("R11 vec%0d wake", i), mode_o, 0);
            clear_inputs();
            step();
        end

        // R8 direct standby on lp rise
        bus_slow = 1; cfg_lp_req = 1;
        step();
        chk("R8 direct standby", mode_o, 3);
        // R11 ignore STOP while in standby
        cfg_lp_req = 0; cfg_stop_en = 1; cfg_ppd_ctl = 1; stop_exec = 1;
        step();
        stop_exec = 0;
        chk("R11 stop ignored", mode_o, 3);
        chk("R10 stby no gate", logic_gate_o, 0);
        do_wake();
        chk("R11 wake to run", mode_o, 0);
        clear_inputs();
        step();

        // R8 lp rise with fast clock ignored
        cfg_lp_req = 1; bus_slow = 0;
        step();
        chk("R8 fast rise ignored", mode_o, 0);
        // R8 holding lp with slow later gives no new rise
        bus_slow = 1;
        step();
        chk("R8 level no entry", mode_o, 0);
        clear_inputs();
        step();

        // R8 lp rise with debug set ignored
        cfg_lp_req = 1; bus_slow = 1; cfg_dbg_stop = 1;
        step();
        chk("R8 debug rise ignored", mode_o, 0);
        clear_inputs();
        step();

        // R11 wake in RUN no effect
        wake = 1; step(); wake = 0;
        chk("R11 wake in run", mode_o, 0);

        // R11 in WAIT, lp rise ignored
        cfg_wait_en = 1; stop_exec = 1; step(); stop_exec = 0; cfg_wait_en = 0;
        chk("R2 wait", mode_o, 1);
        cfg_lp_req = 1; bus_slow = 1; step();
        chk("R11 lp ignored in wait", mode_o, 1);
        do_wake();
        clear_inputs();
        step();

        // R9 conflict
        chk("R9 err clear before", cfg_err_o, 0);
        cfg_stop_en = 1; cfg_lp_req = 1; cfg_ppd_ctl = 1; bus_slow = 1; stop_exec = 1;
        step();
        stop_exec = 0;
        chk("R9 plain stop", mode_o, 2);
        chk("R9 err set", cfg_err_o, 1);
        clear_inputs();
        do_wake();
        step();
        chk("R9 err sticky", cfg_err_o, 1);
        rst = 1; step(); rst = 0;
        chk("R1 err cleared by reset", cfg_err_o, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule